// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer with Phase Dither

This block generates a cosine and sine pair at a programmable frequency. It produces one new sample for each clock cycle in which `sample_en` is high. A wide phase accumulator advances by an unsigned tuning word on every enabled sample and wraps modulo 2^ACC_W. The output frequency is therefore tune_word·fs/2^ACC_W, and the finest frequency step is fs/2^ACC_W.

To turn the accumulator into a narrower waveform-table address, the block adds half an address step and keeps the top bits. The address is thus the phase rounded to the nearest table point rather than truncated. A small pseudo-random offset can be added to the quantizer input first. This breaks up the periodic phase error, so that its spurs spread into a flat noise floor. The stored phase is never altered by the dither.

A quarter-wave table (the default) or a full-wave table maps the address to signed amplitudes. A conjugate control negates the sine output, so that the pair (cos θ, −sin θ) can drive a complex down-converter.

Top module: `qdds_core`

## Requirements
- R1: The phase used by sample n is the modulo-2^ACC_W sum of the tuning words applied on all earlier enabled samples since reset. The first sample after reset therefore uses phase 0.
- R2: On a cycle with `sample_en` low, the accumulator does not advance, `out_valid` stays low two edges later, and `cos_out` and `sin_out` hold their values.
- R3: The table address is the phase plus the dither offset plus 2^(ACC_W−ADDR_W−1), shifted right by ACC_W−ADDR_W and taken modulo 2^ADDR_W. A rounded result of 2^ADDR_W becomes address 0.
- R4: For address a, with A = 2^(AMP_W−1)−1 and N = 2^ADDR_W, `cos_out` is round(A·cos(2πa/N)) and `sin_out` is round(A·sin(2πa/N)), in two's complement and within 1 LSB. The four quadrant points are exact: a=0 gives (A,0), N/4 gives (0,A), N/2 gives (−A,0) and 3N/4 gives (0,−A).
- R5: When `conj_en` is high on the enabling cycle, that sample's `sin_out` is negated. `cos_out` is unchanged.
- R6: When `dither_en` is high, a pseudo-random offset in [−2^(ACC_W−ADDR_W−3), 2^(ACC_W−ADDR_W−3)) is added at the quantizer input only. The address then stays within one step of the undithered address, and the stored phase is unaffected.
- R7: Each cycle with `sample_en` high produces exactly one `out_valid` pulse, two rising edges later. The outputs of that sample appear in the same cycle as the pulse.
- R8: A new tuning word takes effect on the next enabled sample without a phase jump. The sample after the change uses the old phase plus the new word.
- R9: A synchronous active-low reset clears the accumulator, `out_valid`, `cos_out` and `sin_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | Produce one sample this cycle |
| tune_word | input | ACC_W | Unsigned phase step per sample |
| dither_en | input | 1 | Add pseudo-random offset at the quantizer |
| conj_en | input | 1 | Negate the sine output for this sample |
| cos_out | output | AMP_W | Signed cosine sample |
| sin_out | output | AMP_W | Signed sine sample (negated in conjugate mode) |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Two functions can act on the same enabled edge. The rounding carry can wrap the address back to 0 while a new tuning word is loaded into the accumulator. The bench provokes this by parking the phase exactly half an address step below full scale and changing the tuning word on that same sample. It judges the result in two ways. First, the sample must come out as exactly (A, 0); a truncating quantizer would give the last table entry instead. Second, the next sample must sit at the parked phase plus the new word, which shows that neither the wrap nor the change disturbed the accumulator.

// File: rtl/qdds_pkg.sv
`timescale 1ns/1ps
// qdds_pkg: shared types and elaboration-time helpers for the quadrature DDS.
// Assumes addr_w < 31 and amp_w < 32 so all integer arithmetic fits an int.
package qdds_pkg;

    typedef enum logic [1:0] {
        QD_FIRST  = 2'd0,
        QD_SECOND = 2'd1,
        QD_THIRD  = 2'd2,
        QD_FOURTH = 2'd3
    } quadrant_e;

    localparam real TWO_PI = 6.283185307179586;

    // Largest positive code used, so the range stays symmetric.
    function automatic int full_scale(input int amp_w);
        return (1 << (amp_w - 1)) - 1;
    endfunction

    // Rounded sine code for table point k of a 2^addr_w point circle.
    function automatic int sine_code(input int k, input int addr_w, input int amp_w);
        real ang;
        real v;
        ang = TWO_PI * real'(k) / real'(1 << addr_w);
        v   = real'(full_scale(amp_w)) * $sin(ang);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/qdds_dither_lfsr.sv
`timescale 1ns/1ps
// qdds_dither_lfsr: free-running Galois LFSR producing a small signed dither
// offset, sign-extended to the accumulator width and forced to zero when
// disabled. Assumes TAPS has its top bit set, so the state never reaches 0.
module qdds_dither_lfsr #(
    parameter int               LFSR_W = 32,
    parameter int               OUT_W  = 18,
    parameter int               ACC_W  = 32,
    parameter logic [LFSR_W-1:0] TAPS  = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] SEED  = 32'hACE1_2468
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    output logic [ACC_W-1:0] dither
);
    localparam int EXT_W = ACC_W - OUT_W;

    logic [LFSR_W-1:0] state;
    logic [OUT_W-1:0]  raw;

    // Advance the register every clock, independent of sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {1'b0, state[LFSR_W-1:1]} ^ (state[0] ? TAPS : '0);
    end

    // Fold both ends of the state into one offset word.
    assign raw = state[OUT_W-1:0] ^ state[LFSR_W-1 -: OUT_W];

    // Sign-extend, or give zero when dither is off.
    assign dither = enable ? {{EXT_W{raw[OUT_W-1]}}, raw} : '0;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R6

endmodule

// File: rtl/qdds_phase_quant.sv
`timescale 1ns/1ps
// qdds_phase_quant: phase accumulator and rounding quantizer. On an enabled
// cycle it registers the rounded table address of the current phase (plus
// dither), then steps the phase by the tuning word. Dither reaches only the
// quantizer, never the stored phase. Assumes ACC_W - ADDR_W >= 3.
module qdds_phase_quant #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [ACC_W-1:0]  tune_word,
    input  logic [ACC_W-1:0]  dither,
    input  logic              conj_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic              conj_q,
    output logic              vld_q
);
    localparam int                DROP     = ACC_W - ADDR_W;
    localparam int                DITH_W   = DROP - 2;
    localparam logic [ACC_W-1:0]  HALF_LSB = ACC_W'(1) << (DROP - 1);
    localparam longint            DMAX     = longint'(1) <<< (DITH_W - 1);

    logic [ACC_W-1:0]  phase;
    logic [ACC_W-1:0]  quant_in;
    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] trunc_addr;

    // Quantizer input: phase, dither and half an address step.
    assign quant_in  = phase + dither + HALF_LSB;
    // Keep the top bits; a carry out of the top wraps to address 0.
    assign addr_next = ADDR_W'(quant_in >> DROP);
    // Plain truncated address, used only by the rounding check.
    assign trunc_addr = ADDR_W'(phase >> DROP);

    // Step the phase and capture the address for each enabled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            addr_q <= '0;
            conj_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= sample_en;
            if (sample_en) begin
                phase  <= phase + tune_word;
                addr_q <= addr_next;
                conj_q <= conj_en;
            end
        end
    end

    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && dither == '0) |=>
            (addr_q == $past(trunc_addr)) ||
            (addr_q == $past(trunc_addr) + ADDR_W'(1)));  // R3

    AST_DITHER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'($signed(dither)) >= -DMAX) &&
        (longint'($signed(dither)) <  DMAX));  // R6

endmodule

// File: rtl/qdds_wave_rom.sv
`timescale 1ns/1ps
// qdds_wave_rom: maps a table address to cosine and sine codes and registers
// them. It can store a quarter wave (folded by quadrant) or a full wave.
// The table is computed at elaboration. The sine is negated when the
// conjugate flag is set.
module qdds_wave_rom #(
    parameter int ADDR_W     = 12,
    parameter int AMP_W      = 14,
    parameter bit FULL_TABLE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic                    in_conj,
    output logic signed [AMP_W-1:0] cos_q,
    output logic signed [AMP_W-1:0] sin_q,
    output logic                    out_vld
);
    import qdds_pkg::*;

    localparam int NPTS = 1 << ADDR_W;
    localparam int QPTS = NPTS / 4;
    localparam int RW   = ADDR_W - 2;
    localparam int AMAX = full_scale(AMP_W);
    localparam logic signed [AMP_W-1:0] CODE_MIN = {1'b1, {(AMP_W-1){1'b0}}};

    logic signed [AMP_W-1:0] cos_c;
    logic signed [AMP_W-1:0] sin_c;

    generate
        if (FULL_TABLE) begin : g_full
            logic signed [AMP_W-1:0] ftab [NPTS];
            logic [ADDR_W-1:0]       cos_idx;
            for (genvar k = 0; k < NPTS; k++) begin : g_ent
                assign ftab[k] = AMP_W'(sine_code(k, ADDR_W, AMP_W));
            end
            // Cosine is the sine a quarter turn ahead.
            assign cos_idx = in_addr + ADDR_W'(QPTS);
            assign sin_c   = ftab[in_addr];
            assign cos_c   = ftab[cos_idx];
        end else begin : g_quarter
            logic signed [AMP_W-1:0] qtab [QPTS+1];
            quadrant_e               quad;
            logic [RW:0]             idx_up;
            logic [RW:0]             idx_dn;
            logic signed [AMP_W-1:0] s_up;
            logic signed [AMP_W-1:0] s_dn;
            for (genvar k = 0; k <= QPTS; k++) begin : g_ent
                assign qtab[k] = AMP_W'(sine_code(k, ADDR_W, AMP_W));
            end
            // Split the address into quadrant and offset within it.
            assign quad   = quadrant_e'(in_addr[ADDR_W-1 -: 2]);
            assign idx_up = {1'b0, in_addr[RW-1:0]};
            assign idx_dn = (RW+1)'(QPTS) - idx_up;
            assign s_up   = qtab[idx_up];
            assign s_dn   = qtab[idx_dn];
            // Fold the quarter wave into all four quadrants.
            always_comb begin
                case (quad)
                    QD_FIRST:  begin sin_c =  s_up; cos_c =  s_dn; end
                    QD_SECOND: begin sin_c =  s_dn; cos_c = -s_up; end
                    QD_THIRD:  begin sin_c = -s_up; cos_c = -s_dn; end
                    default:   begin sin_c = -s_dn; cos_c =  s_up; end
                endcase
            end
        end
    endgenerate

    // Register the amplitudes, applying conjugation to the sine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_q   <= '0;
            sin_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                cos_q <= cos_c;
                sin_q <= in_conj ? -sin_c : sin_c;
            end
        end
    end

    AST_QUAD_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((cos_q < 0 ? -int'(cos_q) : int'(cos_q)) +
                     (sin_q < 0 ? -int'(sin_q) : int'(sin_q)) >= AMAX - 2));  // R4

    AST_AMP_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (cos_q != CODE_MIN) && (sin_q != CODE_MIN));  // R4

endmodule

// File: rtl/qdds_core.sv
`timescale 1ns/1ps
// qdds_core: quadrature DDS top. It chains the dither source, the phase
// accumulator with rounding quantizer, and the waveform table. Latency from
// sample_en to out_valid is two clock edges. Reset is synchronous, active low.
module qdds_core #(
    parameter int ACC_W      = 32,
    parameter int ADDR_W     = 12,
    parameter int AMP_W      = 14,
    parameter bit FULL_TABLE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [ACC_W-1:0]        tune_word,
    input  logic                    dither_en,
    input  logic                    conj_en,
    output logic signed [AMP_W-1:0] cos_out,
    output logic signed [AMP_W-1:0] sin_out,
    output logic                    out_valid
);
    localparam int DITH_W = ACC_W - ADDR_W - 2;

    logic [ACC_W-1:0]  dither;
    logic [ADDR_W-1:0] addr_q;
    logic              conj_q;
    logic              vld_q;
    logic              en_live;

    qdds_dither_lfsr #(
        .LFSR_W (32),
        .OUT_W  (DITH_W),
        .ACC_W  (ACC_W)
    ) u_dither (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (dither_en),
        .dither (dither)
    );

    qdds_phase_quant #(
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .tune_word (tune_word),
        .dither    (dither),
        .conj_en   (conj_en),
        .addr_q    (addr_q),
        .conj_q    (conj_q),
        .vld_q     (vld_q)
    );

    qdds_wave_rom #(
        .ADDR_W     (ADDR_W),
        .AMP_W      (AMP_W),
        .FULL_TABLE (FULL_TABLE)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (vld_q),
        .in_addr (addr_q),
        .in_conj (conj_q),
        .cos_q   (cos_out),
        .sin_q   (sin_out),
        .out_vld (out_valid)
    );

    // A request counts only when it arrives outside reset.
    assign en_live = sample_en && rst_n;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(en_live, 2));  // R7

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_live, 2) && $past(rst_n)) |-> out_valid);  // R7

endmodule

// File: tb/test_qdds_core.sv
`timescale 1ns/1ps
// Directed bench for qdds_core: one task per scenario, each checking itself.
module test_qdds_core;
    localparam int  ACC_W  = 32;
    localparam int  ADDR_W = 12;
    localparam int  AMP_W  = 14;
    localparam int  AFS    = 8191;
    localparam real PI2    = 6.283185307179586;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sample_en = 1'b0;
    logic                    dither_en = 1'b0;
    logic                    conj_en = 1'b0;
    logic [ACC_W-1:0]        tune_word = '0;
    logic signed [AMP_W-1:0] cos_out;
    logic signed [AMP_W-1:0] sin_out;
    logic                    out_valid;

    int               n_chk = 0;
    int               n_fail = 0;
    logic [ACC_W-1:0] acc_m = '0;
    bit               done = 1'b0;

    always #10 clk = ~clk;

    qdds_core i_qdds_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .tune_word (tune_word),
        .dither_en (dither_en),
        .conj_en   (conj_en),
        .cos_out   (cos_out),
        .sin_out   (sin_out),
        .out_valid (out_valid)
    );

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic int exp_amp(input int a, input bit is_sin);
        real ang;
        ang = PI2 * real'(a) / 4096.0;
        return is_sin ? rnd(AFS * $sin(ang)) : rnd(AFS * $cos(ang));
    endfunction

    function automatic int model_addr(input logic [ACC_W-1:0] ph);
        logic [ACC_W-1:0] t;
        t = ph + 32'h0008_0000;
        return int'(t[31:20]);
    endfunction

    task automatic chk(input string req, input string what, input int act,
                       input int expv, input int tol);
        int d;
        n_chk++;
        d = act - expv;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_m = '0;
    endtask

    // One isolated sample: drives inputs, checks valid timing, returns outputs.
    task automatic run_sample(input logic [ACC_W-1:0] ftw, input bit conj,
                              output int c, output int s, output int a);
        @(negedge clk);
        tune_word = ftw;
        conj_en   = conj;
        sample_en = 1'b1;
        a = model_addr(acc_m);
        acc_m = acc_m + ftw;
        @(negedge clk);
        sample_en = 1'b0;
        chk("R7", "out_valid one edge after", int'(out_valid), 0, 0);
        @(negedge clk);
        chk("R7", "out_valid two edges after", int'(out_valid), 1, 0);
        c = int'(cos_out);
        s = int'(sin_out);
    endtask

    task automatic check_sample(input string req, input logic [ACC_W-1:0] ftw,
                                input bit conj);
        int c, s, a, es;
        run_sample(ftw, conj, c, s, a);
        es = exp_amp(a, 1'b1);
        chk(req, "cos", c, exp_amp(a, 1'b0), 1);
        chk(req, "sin", s, conj ? -es : es, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "out_valid in reset", int'(out_valid), 0, 0);
        chk("R9", "cos in reset", int'(cos_out), 0, 0);
        chk("R9", "sin in reset", int'(sin_out), 0, 0);
        rst_n = 1'b1;
        acc_m = '0;
        @(negedge clk);
        chk("R9", "out_valid after reset", int'(out_valid), 0, 0);
    endtask

    task automatic t_first();
        int c, s, a;
        run_sample(32'h0123_4567, 1'b0, c, s, a);
        chk("R1", "first sample cos at phase 0", c, AFS, 0);
        chk("R1", "first sample sin at phase 0", s, 0, 0);
    endtask

    task automatic t_stream();
        logic [ACC_W-1:0] words [6];
        words = '{32'h0123_4567, 32'h1234_5678, 32'h7FFF_FFFF,
                  32'h0000_1000, 32'hDEAD_BEEF, 32'h3333_3333};
        for (int w = 0; w < 6; w++) begin
            for (int k = 0; k < 3; k++) begin
                check_sample((k == 0) ? "R8" : "R1", words[w], 1'b0);
            end
        end
    endtask

    task automatic t_quadrants();
        int ec [4];
        int es [4];
        ec = '{AFS, 0, -AFS, 0};
        es = '{0, AFS, 0, -AFS};
        do_reset();
        @(negedge clk);
        tune_word = 32'h4000_0000;
        conj_en   = 1'b0;
        sample_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 3) sample_en = 1'b0;
            if (i >= 1 && i <= 4) begin
                chk("R7", "back-to-back valid", int'(out_valid), 1, 0);
                chk("R4", "quadrant cos", int'(cos_out), ec[i-1], 0);
                chk("R4", "quadrant sin", int'(sin_out), es[i-1], 0);
            end
            if (i == 5) chk("R7", "valid drops after stream", int'(out_valid), 0, 0);
        end
        acc_m = '0;
    endtask

    task automatic t_round();
        int c, s, a;
        do_reset();
        check_sample("R3", 32'h0007_FFFF, 1'b0);
        run_sample(32'h0000_0001, 1'b0, c, s, a);
        chk("R3", "just below half step stays at 0", s, 0, 0);
        run_sample(32'h0100_0000, 1'b0, c, s, a);
        chk("R3", "half step rounds up to address 1", s, exp_amp(1, 1'b1), 1);
        check_sample("R3", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_wrap_collide();
        int c, s, a;
        do_reset();
        check_sample("R3", 32'hFFF8_0000, 1'b0);
        run_sample(32'h0400_0000, 1'b0, c, s, a);
        chk("R3", "wrap to address 0 cos", c, AFS, 0);
        chk("R3", "wrap to address 0 sin", s, 0, 0);
        run_sample(32'h0000_0000, 1'b0, c, s, a);
        chk("R8", "phase after change on wrap edge addr", a, 64, 0);
        chk("R8", "phase after change on wrap edge sin", s, exp_amp(64, 1'b1), 1);
    endtask

    task automatic t_conj();
        for (int k = 0; k < 4; k++) check_sample("R5", 32'h0ABC_DEF1, 1'b1);
        check_sample("R5", 32'h0ABC_DEF1, 1'b0);
    endtask

    task automatic t_hold();
        int c, s, a;
        run_sample(32'h1357_9BDF, 1'b0, c, s, a);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R2", "no valid while idle", int'(out_valid), 0, 0);
            chk("R2", "cos held while idle", int'(cos_out), c, 0);
            chk("R2", "sin held while idle", int'(sin_out), s, 0);
        end
        check_sample("R2", 32'h0000_0000, 1'b0);
    endtask

    task automatic t_dither();
        int c, s, a, ok;
        dither_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            run_sample(32'h0135_79BD, 1'b0, c, s, a);
            ok = 0;
            for (int d = -1; d <= 1; d++) begin
                int an;
                int dc;
                int ds;
                an = (a + d + 4096) % 4096;
                dc = c - exp_amp(an, 1'b0);
                ds = s - exp_amp(an, 1'b1);
                if (dc <= 1 && dc >= -1 && ds <= 1 && ds >= -1) ok = 1;
            end
            chk("R6", "dithered sample within one address step", ok, 1, 0);
        end
        dither_en = 1'b0;
        for (int k = 0; k < 4; k++) check_sample("R6", 32'h0135_79BD, 1'b0);
    endtask

    task automatic t_midreset();
        int c, s, a;
        check_sample("R1", 32'h2222_2222, 1'b0);
        do_reset();
        chk("R9", "cos cleared by reset", int'(cos_out), 0, 0);
        run_sample(32'h0000_4000, 1'b0, c, s, a);
        chk("R9", "phase restarts at 0 cos", c, AFS, 0);
        chk("R9", "phase restarts at 0 sin", s, 0, 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first();
        t_stream();
        t_quadrants();
        t_round();
        t_wrap_collide();
        t_conj();
        t_hold();
        t_dither();
        t_midreset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule